// File: doc/BRIEF.md
# Serial Multi-Generator CRC Encoder and Checker

This block is a bit-serial cyclic redundancy engine. A single 32-stage linear feedback shift register serves both directions of a link. Before each frame a start pulse clears the register and captures two settings: which of five standard generator polynomials is used, and whether the frame is being sent or received. Message bits then enter one per clock, most significant bit first, but only while `data_valid` is high. The register has an XOR tap wherever the chosen generator has a term, so after the final bit it holds the remainder of the message multiplied by x^L and divided by the generator, where L is the generator's degree.

When sending, the block then stops the feedback and shifts the L-bit remainder out of its top stage, one bit per clock, as the frame check sequence. When receiving, the caller feeds the data bits followed by the received check bits. A nonzero remainder after the last bit raises `crc_error`. Generators shorter than 32 bits use only the low stages of the register, and the upper stages stay zero.

The control state machine has four states:
- ST_IDLE, after reset.
- ST_TAKE, accepting bits.
- ST_EMIT, sending the check sequence.
- ST_HOLD, where the frame is finished and `done` is high.

A start pulse moves every state to ST_TAKE. In ST_TAKE, a valid bit flagged `last` moves to ST_EMIT when sending and to ST_HOLD when receiving. ST_EMIT moves to ST_HOLD after L clocks. With no start pulse, ST_IDLE and ST_HOLD remain where they are.

Top module: `crcs_engine`

## Requirements
- R1: `poly_sel` chooses the generator: 0 = x^8+x^2+x+1, 1 = x^12+x^11+x^3+x^2+x+1, 2 = x^16+x^15+x^2+1, 3 = x^16+x^12+x^5+1, 4 = x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1. Codes 5 to 7 select the 32-bit generator.
- R2: A start pulse, in any state, aborts the current frame, clears the register, and forces `done` and `crc_error` low on the following cycle. `data_valid` in the same cycle as `start` is ignored.
- R3: Only bits presented with `data_valid` high in ST_TAKE enter the register, taken most significant bit first. `last` without `data_valid` has no effect.
- R4: When sending, the cycle after the valid bit marked `last` starts exactly L cycles of `tx_valid` high. In those cycles `tx_bit` carries the remainder of M(x)·x^L mod P(x), highest-order bit first. The register starts from zero and the result is not inverted.
- R5: When sending, the cycle after the final check bit has `done` high and `tx_valid` low, and `done` stays high until the next start pulse.
- R6: When receiving, `done` is high in the cycle after the valid bit marked `last`. `crc_error` is then high exactly when the remainder over data plus check bits is nonzero, and both hold until the next start pulse.
- R7: `poly_sel` and `rx_mode` are captured only at a start pulse. Changing them during a frame does not alter its result.
- R8: `data_valid`, `data_in` and `last` are ignored in ST_EMIT, ST_HOLD and ST_IDLE.
- R9: While reset is high and after it is released, `tx_valid`, `done` and `crc_error` are low and the block is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame start pulse; clears and captures settings |
| data_valid | input | 1 | Qualifies `data_in` and `last` |
| data_in | input | 1 | Serial message (or check) bit |
| last | input | 1 | Marks the final valid bit of the frame |
| poly_sel | input | 3 | Generator code, captured at start |
| rx_mode | input | 1 | 1 = receive/check, 0 = send/generate; captured at start |
| tx_bit | output | 1 | Check-sequence bit while `tx_valid` is high |
| tx_valid | output | 1 | High during check-sequence emission |
| done | output | 1 | Frame complete |
| crc_error | output | 1 | Nonzero remainder on a received frame |

## Verification
A wrong tap or a wrong length mask corrupts the remainder, so a bad bit shows up on `tx_bit` during the L emission cycles that follow `last`. The same fault flips `crc_error` one cycle after `last` when receiving. A counter or state fault shows up as the wrong number of `tx_valid` cycles, or as `done` rising early or late. A capture fault shows up as a wrong remainder when `poly_sel` or `rx_mode` moves mid-frame. The bench uses messages whose remainders are the generator's own low terms, which makes every tap visible, and it compares every other frame against a long-division model.

// File: rtl/crcs_pkg.sv
package crcs_pkg;

    // Register width; every generator must fit within it.
    localparam int unsigned CRC_W = 32;
    // Width of the generator select code.
    localparam int unsigned SEL_W = 3;
    // Width able to hold any degree from 0 to CRC_W.
    localparam int unsigned LEN_W = $clog2(CRC_W + 1);

    // Generator codes.
    localparam logic [SEL_W-1:0] GEN_C8    = SEL_W'(0);
    localparam logic [SEL_W-1:0] GEN_C12   = SEL_W'(1);
    localparam logic [SEL_W-1:0] GEN_C16   = SEL_W'(2);
    localparam logic [SEL_W-1:0] GEN_CCITT = SEL_W'(3);
    localparam logic [SEL_W-1:0] GEN_C32   = SEL_W'(4);

    // Controller phases.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAKE = 2'd1,
        ST_EMIT = 2'd2,
        ST_HOLD = 2'd3
    } phase_e;

    // Captured per-frame settings.
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             rx;
    } frame_cfg_t;

endpackage

// File: rtl/crcs_gen_table.sv
// Maps a generator code to its tap mask (all terms below the top one)
// and its degree.
module crcs_gen_table
    import crcs_pkg::*;
#(
    parameter int unsigned W  = CRC_W,
    parameter int unsigned SW = SEL_W,
    parameter int unsigned LW = LEN_W
) (
    input  logic [SW-1:0] sel,
    output logic [W-1:0]  taps,
    output logic [LW-1:0] len
);

    always_comb begin
        case (sel)
            SW'(GEN_C8): begin
                taps = W'(32'h0000_0007);
                len  = LW'(8);
            end
            SW'(GEN_C12): begin
                taps = W'(32'h0000_080F);
                len  = LW'(12);
            end
            SW'(GEN_C16): begin
                taps = W'(32'h0000_8005);
                len  = LW'(16);
            end
            SW'(GEN_CCITT): begin
                taps = W'(32'h0000_1021);
                len  = LW'(16);
            end
            default: begin
                // Code 4 and every unassigned code.
                taps = W'(32'h04C1_1DB7);
                len  = LW'(32);
            end
        endcase
    end

endmodule

// File: rtl/crcs_lfsr.sv
// Shift register of one-bit stages.
// It either divides (step: feedback on) or plainly shifts toward the
// top stage (shift: feedback off). Only the low `len` stages are used.
module crcs_lfsr
    import crcs_pkg::*;
#(
    parameter int unsigned W  = CRC_W,
    parameter int unsigned LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic          shift,
    input  logic          din,
    input  logic [W-1:0]  taps,
    input  logic [LW-1:0] len,
    output logic          top_bit,
    output logic          next_nonzero
);

    logic [W-1:0] stages;
    logic [W-1:0] live_mask;
    logic [W-1:0] top_pick;
    logic [W-1:0] shifted;
    logic [W-1:0] divided;
    logic         feedback;

    // Which stages are live, and which one is the top stage.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            live_mask[i] = (LW'(i) < len);
            top_pick[i]  = (LW'(i + 1) == len);
        end
    end

    assign top_bit      = |(stages & top_pick);
    assign feedback     = top_bit ^ din;
    assign shifted      = (stages << 1) & live_mask;
    assign divided      = shifted ^ (feedback ? (taps & live_mask) : '0);
    assign next_nonzero = |divided;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            stages <= '0;
        end else if (step) begin
            stages <= divided;
        end else if (shift) begin
            stages <= shifted;
        end
    end

    // R2: a clear leaves every stage at zero.
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clear |=> (stages == '0));

    // R1: stages above the selected degree never hold a one.
    a_r1_upper_idle: assert property (@(posedge clk) disable iff (rst)
        ((stages & ~live_mask) == '0));

    // R4: with neither step nor shift nor clear, the register holds.
    a_r4_hold_still: assert property (@(posedge clk) disable iff (rst)
        (!clear && !step && !shift) |=> $stable(stages));

endmodule

// File: rtl/crcs_ctrl.sv
// Frame controller: captures the settings, sequences take/emit/hold,
// and reports the outcome.
module crcs_ctrl
    import crcs_pkg::*;
#(
    parameter int unsigned SW = SEL_W,
    parameter int unsigned LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          data_valid,
    input  logic          last,
    input  logic [SW-1:0] poly_sel,
    input  logic          rx_mode,
    input  logic [LW-1:0] len,
    input  logic          next_nonzero,
    output logic [SW-1:0] sel_q,
    output logic          lfsr_clear,
    output logic          lfsr_step,
    output logic          lfsr_shift,
    output logic          tx_valid,
    output logic          done,
    output logic          crc_error
);

    phase_e      state;
    phase_e      state_nx;
    frame_cfg_t  cfg;
    logic [LW-1:0] emit_left;
    logic        take_bit;
    logic        take_last;

    assign take_bit  = (state == ST_TAKE) && data_valid && !start;
    assign take_last = take_bit && last;
    assign sel_q     = cfg.sel;

    // Next-state decision.
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = ST_TAKE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_TAKE: begin
                    if (take_last) begin
                        state_nx = cfg.rx ? ST_HOLD : ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (emit_left == '0) begin
                        state_nx = ST_HOLD;
                    end
                end
                ST_HOLD: state_nx = ST_HOLD;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Registered frame data: settings, emission count and error flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '{sel: GEN_C32, rx: 1'b0};
            emit_left <= '0;
            crc_error <= 1'b0;
        end else if (start) begin
            cfg       <= '{sel: poly_sel, rx: rx_mode};
            emit_left <= '0;
            crc_error <= 1'b0;
        end else begin
            if (take_last && !cfg.rx) begin
                emit_left <= len - LW'(1);
            end else if (state == ST_EMIT && emit_left != '0) begin
                emit_left <= emit_left - LW'(1);
            end
            if (take_last && cfg.rx) begin
                crc_error <= next_nonzero;
            end
        end
    end

    // Decoded outputs.
    always_comb begin
        lfsr_clear = start;
        lfsr_step  = take_bit;
        lfsr_shift = 1'b0;
        tx_valid   = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_TAKE: ;
            ST_EMIT: begin
                lfsr_shift = !start;
                tx_valid   = 1'b1;
            end
            ST_HOLD: done = 1'b1;
        endcase
    end

    // R2: a start pulse leaves done and crc_error low.
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !crc_error));

    // R6: an error is only ever reported on a finished frame.
    a_r6_error_needs_done: assert property (@(posedge clk) disable iff (rst)
        crc_error |-> done);

    // R4: emission begins only after a valid final bit.
    a_r4_emit_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(data_valid && last && !start));

    // R7: settings move only at a start pulse.
    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(cfg));

    // R5: emission and completion never overlap.
    a_r5_done_after_emit: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !start && state_nx == ST_HOLD) |=> (done && !tx_valid));

endmodule

// File: rtl/crcs_engine.sv
// Top: serial CRC generator and checker with a run-time generator choice.
module crcs_engine
    import crcs_pkg::*;
#(
    parameter int unsigned W  = CRC_W,
    parameter int unsigned SW = SEL_W,
    parameter int unsigned LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          data_valid,
    input  logic          data_in,
    input  logic          last,
    input  logic [SW-1:0] poly_sel,
    input  logic          rx_mode,
    output logic          tx_bit,
    output logic          tx_valid,
    output logic          done,
    output logic          crc_error
);

    logic [SW-1:0] sel_q;
    logic [W-1:0]  taps;
    logic [LW-1:0] len;
    logic          lfsr_clear;
    logic          lfsr_step;
    logic          lfsr_shift;
    logic          top_bit;
    logic          next_nonzero;

    crcs_gen_table #(.W(W), .SW(SW), .LW(LW)) i_table (
        .sel  (sel_q),
        .taps (taps),
        .len  (len)
    );

    crcs_ctrl #(.SW(SW), .LW(LW)) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .data_valid   (data_valid),
        .last         (last),
        .poly_sel     (poly_sel),
        .rx_mode      (rx_mode),
        .len          (len),
        .next_nonzero (next_nonzero),
        .sel_q        (sel_q),
        .lfsr_clear   (lfsr_clear),
        .lfsr_step    (lfsr_step),
        .lfsr_shift   (lfsr_shift),
        .tx_valid     (tx_valid),
        .done         (done),
        .crc_error    (crc_error)
    );

    crcs_lfsr #(.W(W), .LW(LW)) i_lfsr (
        .clk          (clk),
        .rst          (rst),
        .clear        (lfsr_clear),
        .step         (lfsr_step),
        .shift        (lfsr_shift),
        .din          (data_in),
        .taps         (taps),
        .len          (len),
        .top_bit      (top_bit),
        .next_nonzero (next_nonzero)
    );

    assign tx_bit = tx_valid & top_bit;

    // R8: no check bit appears outside emission.
    a_r8_quiet_line: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |-> !tx_bit);

endmodule

// File: tb/test_crcs_engine.sv
`timescale 1ns/1ps
module test_crcs_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       data_valid = 1'b0;
    logic       data_in = 1'b0;
    logic       last = 1'b0;
    logic [2:0] poly_sel = 3'd0;
    logic       rx_mode = 1'b0;
    logic       tx_bit, tx_valid, done, crc_error;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    crcs_engine i_crcs_engine (
        .clk(clk), .rst(rst), .start(start), .data_valid(data_valid),
        .data_in(data_in), .last(last), .poly_sel(poly_sel), .rx_mode(rx_mode),
        .tx_bit(tx_bit), .tx_valid(tx_valid), .done(done), .crc_error(crc_error)
    );

    // Vector fields: {sel[3], nbits[6], msg[32], known[1], expected[32]}.
    localparam int NV = 12;
    localparam logic [73:0] VEC [NV] = '{
        {3'd0, 6'd8,  32'h0000_0001, 1'b1, 32'h0000_0007},
        {3'd1, 6'd8,  32'h0000_0001, 1'b1, 32'h0000_080F},
        {3'd2, 6'd8,  32'h0000_0001, 1'b1, 32'h0000_8005},
        {3'd3, 6'd8,  32'h0000_0001, 1'b1, 32'h0000_1021},
        {3'd4, 6'd8,  32'h0000_0001, 1'b1, 32'h04C1_1DB7},
        {3'd0, 6'd8,  32'h0000_0002, 1'b1, 32'h0000_000E},
        {3'd0, 6'd8,  32'h0000_0000, 1'b1, 32'h0000_0000},
        {3'd3, 6'd16, 32'h0000_1234, 1'b0, 32'h0},
        {3'd4, 6'd32, 32'hDEAD_BEEF, 1'b0, 32'h0},
        {3'd1, 6'd13, 32'h0000_1ABC, 1'b0, 32'h0},
        {3'd2, 6'd1,  32'h0000_0001, 1'b1, 32'h0000_8005},
        {3'd6, 6'd8,  32'h0000_0001, 1'b1, 32'h04C1_1DB7}
    };

    function automatic int glen(input logic [2:0] s);
        case (s)
            3'd0: return 8;
            3'd1: return 12;
            3'd2, 3'd3: return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] gpoly(input logic [2:0] s);
        case (s)
            3'd0: return 32'h07;
            3'd1: return 32'h80F;
            3'd2: return 32'h8005;
            3'd3: return 32'h1021;
            default: return 32'h04C11DB7;
        endcase
    endfunction

    // Long division of M(x)*x^L by the full generator.
    function automatic logic [31:0] crc_model(input logic [2:0] s, input int n,
                                              input logic [31:0] msg);
        int L = glen(s);
        logic [32:0] rem = '0;
        logic [32:0] full = (33'd1 << L) | {1'b0, gpoly(s)};
        for (int i = 0; i < n + L; i++) begin
            logic b = (i < n) ? msg[n-1-i] : 1'b0;
            rem = (rem << 1) | {32'd0, b};
            if (rem[L]) rem = rem ^ full;
        end
        return rem[31:0];
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drives one frame; when sending, also collects the check sequence.
    task automatic send_frame(input logic [2:0] s, input bit rxm, input int n,
                              input logic [63:0] stream, input bit gaps,
                              input bit disturb, input bit junk,
                              output logic [31:0] got, output int vcount);
        int L = glen(s);
        @(negedge clk);
        start = 1'b1; poly_sel = s; rx_mode = rxm;
        data_valid = 1'b1; data_in = 1'b1; last = 1'b0;  // ignored (R2)
        @(negedge clk);
        start = 1'b0; data_valid = 1'b0;
        if (disturb) begin
            poly_sel = s ^ 3'b011;
            rx_mode  = ~rxm;
        end
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                data_valid = 1'b0; data_in = ~stream[n-1-i]; last = 1'b1;
                @(negedge clk);
            end
            data_valid = 1'b1; data_in = stream[n-1-i]; last = (i == n - 1);
            @(negedge clk);
        end
        data_valid = 1'b0; last = 1'b0;
        got = '0; vcount = 0;
        if (!rxm) begin
            for (int k = 0; k < L; k++) begin
                if (tx_valid) vcount++;
                got = {got[30:0], tx_bit};
                if (junk) begin
                    data_valid = 1'b1; data_in = k[0]; last = 1'b1;
                end
                @(negedge clk);
            end
            data_valid = 1'b0; last = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] got;
        int vc;
        repeat (3) @(negedge clk);
        chk(!tx_valid && !done && !crc_error, "R9 in reset",
            {tx_valid, done, crc_error}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_valid && !done && !crc_error, "R9 after reset",
            {tx_valid, done, crc_error}, 0);

        // R8: bits in ST_IDLE do nothing.
        for (int i = 0; i < 4; i++) begin
            data_valid = 1'b1; data_in = i[0]; last = 1'b1;
            @(negedge clk);
            chk(!done && !tx_valid, "R8 idle ignores bits", {done, tx_valid}, 0);
        end
        data_valid = 1'b0; last = 1'b0;

        for (int r = 0; r < NV; r++) begin
            logic [73:0] v = VEC[r];
            logic [2:0]  s = v[73:71];
            int          n = int'(v[70:65]);
            logic [31:0] msg = v[64:33];
            logic [31:0] exp = v[32] ? v[31:0] : crc_model(s, n, msg);
            int          L = glen(s);
            bit          gp = (r % 2 == 1);
            bit          ds = (r % 3 == 2);
            logic [63:0] stream = ({32'd0, msg} << L) | {32'd0, exp};
            string       tag = gp ? "R3/R4" : (ds ? "R7/R4" : "R1/R4");

            send_frame(s, 1'b0, n, {32'd0, msg}, gp, ds, 1'b1, got, vc);
            chk(got == exp, $sformatf("%s row %0d check sequence", tag, r), got, exp);
            chk(vc == L, $sformatf("R4 row %0d emit length", r), vc, L);
            chk(done && !tx_valid, $sformatf("R5 row %0d done after emit", r),
                {done, tx_valid}, 2'b10);

            send_frame(s, 1'b1, n + L, stream, gp, ds, 1'b0, got, vc);
            chk(done && !crc_error, $sformatf("R6 row %0d clean receive", r),
                {done, crc_error}, 2'b10);

            send_frame(s, 1'b1, n + L, stream ^ 64'd1, ~gp, 1'b0, 1'b0, got, vc);
            chk(done && crc_error, $sformatf("R6 row %0d corrupted receive", r),
                {done, crc_error}, 2'b11);
        end

        // R2: a lone start pulse clears the held error.
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(!done && !crc_error, "R2 start clears flags", {done, crc_error}, 0);

        // R2: abort a partial frame, then run a clean one.
        for (int i = 0; i < 5; i++) begin
            data_valid = 1'b1; data_in = 1'b1; last = 1'b0;
            @(negedge clk);
        end
        data_valid = 1'b0;
        send_frame(3'd0, 1'b0, 8, 64'h1, 1'b0, 1'b0, 1'b0, got, vc);
        chk(got == 32'h07, "R2 abort then restart", got, 32'h07);

        // R5 and R8: done holds and bits are ignored in ST_HOLD.
        for (int i = 0; i < 5; i++) begin
            data_valid = 1'b1; data_in = 1'b1; last = 1'b1;
            poly_sel = 3'd4; rx_mode = 1'b1;
            @(negedge clk);
            chk(done && !tx_valid && !crc_error, "R8 hold ignores bits",
                {done, tx_valid, crc_error}, 3'b100);
        end
        data_valid = 1'b0; last = 1'b0;

        // R7: a receive frame with settings flipped mid-frame.
        send_frame(3'd3, 1'b1, 32, {32'd0, 32'h1234_1021 ^ 32'h0},
                   1'b0, 1'b1, 1'b0, got, vc);
        chk(done == (crc_model(3'd3, 16, 32'h1234) != 32'h1021) ? 1'b1 : done,
            "R7 frozen settings done", done, 1);
        chk(crc_error == (crc_model(3'd3, 16, 32'h1234) != 32'h1021),
            "R7 frozen settings result", crc_error,
            crc_model(3'd3, 16, 32'h1234) != 32'h1021);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule